// File: doc/BRIEF.md
# Serial Register Port with Two-Frame Readback

This block is the device-side register port of a configurable output converter. A host talks to it with 32-bit words on a mode-0 serial bus (data sampled on the rising clock edge, shifted on the falling edge, most significant bit first), and each word is framed by an active-low select. The top byte of a word is a command byte whose bit 7 marks a write and whose low five bits give a register address. The middle 16 bits carry data. The low byte is an integrity byte, and this block never uses it. All serial inputs are brought into the system clock domain through two-flop synchronizers, and the bus is sampled there.

Reads take two words. The host first writes a register address into the readback selector. During the next word, usually a no-op write to address 0x00, the block shifts the selected register out in bits 23:8. The word it sends back is loaded when select falls. A key register accepts 16-bit action codes: a software reset that needs two codes in sequence, a calibration refresh, and a watchdog kick. A calibration refresh keeps a busy flag set for `CAL_CYCLES` system clocks. A diagnostic flags register is cleared by writing ones to it. Writing a fixed code to the diagnostic configuration register reports integrity checking as disabled.

The design is built from three state machines. The link machine has the states LINK_IDLE and LINK_SHIFT. It moves from LINK_IDLE to LINK_SHIFT when select falls and returns to LINK_IDLE when select rises. The key machine has the states KEY_IDLE and KEY_ARMED. The first reset code moves it from KEY_IDLE to KEY_ARMED. Any key write moves it from KEY_ARMED back to KEY_IDLE, except a repeat of the first reset code, which keeps it armed. The calibration machine has the states CAL_IDLE and CAL_RUN. A start moves it from CAL_IDLE to CAL_RUN, and it returns to CAL_IDLE when its counter expires or on a software reset.

Top module: `spi_regif`

## Requirements
- R1: A word is accepted only if exactly 32 rising serial clock edges occur while select is low. An accepted write stores bits 23:8 into the register addressed by bits 28:24. A word of any other length changes nothing.
- R2: Writing address A into the readback selector (0x13) makes the next word return register A in bits 23:8 on `miso`. The other bits of the returned word are 0. The selector reads back its own 5-bit value.
- R3: Reads of addresses other than 0x01, 0x06, 0x10, 0x13, 0x14 and 0x16 return 0, including the key register 0x08. Writes to unimplemented addresses have no effect.
- R4: After reset, registers 0x01, 0x06, 0x10 and 0x13 read 0. The diagnostic results register (0x14) reads 0x0004, with bit 2 meaning "reset occurred". The status register (0x16) reads 0x0001, with bit 0 meaning integrity checking on. The port `crc_en` is 1 and `dac_code` is 0.
- R5: Key 0x15FA followed by key 0xAF51 in the next key write performs a software reset: every register returns to its R4 value. Writes to non-key registers between the two codes do not break the sequence.
- R6: Any key write other than 0xAF51 cancels an armed reset. Key 0xAF51 without an armed reset, or any unknown key value, sets diagnostic bit 1.
- R7: Key 0xFCBA sets bit 15 of the diagnostic results register and bit 1 of status for `CAL_CYCLES` system clocks, after which both read 0.
- R8: A write to 0x06 that changes bits 3:0 (range) or bits 15:8 (slew) restarts the busy flag of R7. A write that changes only bits 7:4 does not.
- R9: Key 0x0D06 produces exactly one single-cycle pulse on `wdt_kick`.
- R10: Writing 0x5C3A to 0x10 clears status bit 0 and `crc_en`. The low byte of a word never affects the result.
- R11: Writing a value to 0x14 clears each of bits 2:0 that is written as 1 and leaves the other bits unchanged.
- R12: A word whose bit 31 is 0, or whose bits 30:29 are nonzero, writes nothing and sets diagnostic bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host, idle low |
| cs_n | input | 1 | Active-low word select |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| dac_code | output | 16 | Converter input code register (0x01) |
| dac_cfg | output | 16 | Converter configuration register (0x06) |
| crc_en | output | 1 | High while integrity checking is reported as on |
| wdt_kick | output | 1 | Single-cycle watchdog restart pulse |

## Verification
Directed sequences cover the key machine:
- a clean reset pair;
- a pair broken by a watchdog key, which must not reset;
- a pair separated by an ordinary register write, which must reset;
- lone and unknown codes, which must raise the bad-key flag.

Truncated words and words with illegal command bits are sent to show that they are dropped. The busy flag is read inside and after its window, and after configuration writes that change range, slew or only the middle bits, which separates a real retrigger from a spurious one. A seeded random stream of writes and two-frame reads over the whole address space, compared with a bench model, tells selector handling and decoding of unimplemented addresses apart from correct storage.

// File: rtl/spi_regif_pkg.sv
package spi_regif_pkg;

    localparam int DATA_W = 16;
    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] A_DAC_IN   = 5'h01;
    localparam logic [ADDR_W-1:0] A_DAC_CFG  = 5'h06;
    localparam logic [ADDR_W-1:0] A_KEY      = 5'h08;
    localparam logic [ADDR_W-1:0] A_DIAG_CFG = 5'h10;
    localparam logic [ADDR_W-1:0] A_RB_SEL   = 5'h13;
    localparam logic [ADDR_W-1:0] A_DIAG_RES = 5'h14;
    localparam logic [ADDR_W-1:0] A_STATUS   = 5'h16;

    localparam logic [DATA_W-1:0] K_RST_FIRST  = 16'h15FA;
    localparam logic [DATA_W-1:0] K_RST_SECOND = 16'hAF51;
    localparam logic [DATA_W-1:0] K_CAL        = 16'hFCBA;
    localparam logic [DATA_W-1:0] K_WDT        = 16'h0D06;
    localparam logic [DATA_W-1:0] CRC_OFF_CODE = 16'h5C3A;

    localparam int FLAG_W = 3;
    localparam logic [FLAG_W-1:0] FLAGS_RESET = 3'b100;

    typedef enum logic { LINK_IDLE, LINK_SHIFT } link_state_t;
    typedef enum logic { KEY_IDLE,  KEY_ARMED  } key_state_t;
    typedef enum logic { CAL_IDLE,  CAL_RUN    } cal_state_t;

endpackage

// File: rtl/spi_regif_link.sv
module spi_regif_link
    import spi_regif_pkg::*;
#(
    parameter int FRAME_BITS = 32,
    parameter int KEEP_BITS  = 24
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sclk,
    input  logic                  cs_n,
    input  logic                  mosi,
    input  logic [FRAME_BITS-1:0] tx_word,
    output logic                  miso,
    output logic                  frame_done,
    output logic [KEEP_BITS-1:0]  rx_word
);
    localparam int CNT_W = $clog2(FRAME_BITS + 2);

    logic [2:0] sclk_q;
    logic [2:0] cs_q;
    logic [1:0] mosi_q;
    logic       sclk_rise, sclk_fall, cs_fall, cs_rise;

    link_state_t            state_q, state_d;
    logic [FRAME_BITS-1:0]  rx_q, tx_q;
    logic [CNT_W-1:0]       cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q <= '0;
            cs_q   <= '1;
            mosi_q <= '0;
        end else begin
            sclk_q <= {sclk_q[1:0], sclk};
            cs_q   <= {cs_q[1:0], cs_n};
            mosi_q <= {mosi_q[0], mosi};
        end
    end

    assign sclk_rise = sclk_q[1] & ~sclk_q[2];
    assign sclk_fall = ~sclk_q[1] & sclk_q[2];
    assign cs_fall   = ~cs_q[1] & cs_q[2];
    assign cs_rise   = cs_q[1] & ~cs_q[2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LINK_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LINK_IDLE:  if (cs_fall) state_d = LINK_SHIFT;
            LINK_SHIFT: if (cs_rise) state_d = LINK_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q       <= '0;
            tx_q       <= '0;
            cnt_q      <= '0;
            frame_done <= 1'b0;
        end else begin
            frame_done <= (state_q == LINK_SHIFT) && cs_rise &&
                          (cnt_q == CNT_W'(FRAME_BITS));
            if (cs_fall) begin
                tx_q  <= tx_word;
                cnt_q <= '0;
            end else if (state_q == LINK_SHIFT) begin
                if (sclk_rise) begin
                    rx_q <= {rx_q[FRAME_BITS-2:0], mosi_q[1]};
                    if (cnt_q <= CNT_W'(FRAME_BITS)) cnt_q <= cnt_q + 1'b1;
                end
                if (sclk_fall) tx_q <= {tx_q[FRAME_BITS-2:0], 1'b0};
            end
        end
    end

    assign miso    = tx_q[FRAME_BITS-1];
    assign rx_word = rx_q[FRAME_BITS-1 -: KEEP_BITS];

endmodule

// File: rtl/spi_regif_keyseq.sv
module spi_regif_keyseq
    import spi_regif_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_wr,
    input  logic [DATA_W-1:0] key_val,
    output logic              soft_rst,
    output logic              cal_go,
    output logic              wdt_go,
    output logic              bad_key
);
    key_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= KEY_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        soft_rst = 1'b0;
        cal_go   = 1'b0;
        wdt_go   = 1'b0;
        bad_key  = 1'b0;
        if (key_wr) begin
            state_d = KEY_IDLE;
            case (key_val)
                K_RST_FIRST:  state_d = KEY_ARMED;
                K_RST_SECOND: begin
                    if (state_q == KEY_ARMED) soft_rst = 1'b1;
                    else                      bad_key  = 1'b1;
                end
                K_CAL:        cal_go  = 1'b1;
                K_WDT:        wdt_go  = 1'b1;
                default:      bad_key = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/spi_regif_caltimer.sv
module spi_regif_caltimer
    import spi_regif_pkg::*;
#(
    parameter int CYCLES = 800
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic start,
    output logic busy
);
    localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;

    cal_state_t    state_q, state_d;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CAL_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CAL_IDLE: if (!clr && start) state_d = CAL_RUN;
            CAL_RUN:  if (clr)                      state_d = CAL_IDLE;
                      else if (!start && cnt_q == '0) state_d = CAL_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                   cnt_q <= '0;
        else if (clr)                                 cnt_q <= '0;
        else if (start)                               cnt_q <= CW'(CYCLES - 1);
        else if (state_q == CAL_RUN && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (state_q == CAL_RUN);

endmodule

// File: rtl/spi_regif.sv
module spi_regif
    import spi_regif_pkg::*;
#(
    parameter int FRAME_BITS = 32,
    parameter int CAL_CYCLES = 800
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sclk,
    input  logic        cs_n,
    input  logic        mosi,
    output logic        miso,
    output logic [15:0] dac_code,
    output logic [15:0] dac_cfg,
    output logic        crc_en,
    output logic        wdt_kick
);
    localparam int KEEP_BITS = FRAME_BITS - 8;
    localparam int PAD_BITS  = FRAME_BITS - 8 - DATA_W;

    logic [KEEP_BITS-1:0]  rx_word;
    logic [FRAME_BITS-1:0] tx_word;
    logic                  frame_done;

    logic                  frm_valid, wr_en, key_wr, cfg_retrig;
    logic [ADDR_W-1:0]     frm_addr;
    logic [DATA_W-1:0]     frm_data;
    logic                  soft_rst, cal_go, wdt_go, bad_key, cal_busy;

    logic [DATA_W-1:0]     dac_in_q, dac_cfg_q, diag_cfg_q, rdata;
    logic [ADDR_W-1:0]     rb_sel_q;
    logic [FLAG_W-1:0]     flags_q, flags_d;

    spi_regif_link #(.FRAME_BITS(FRAME_BITS), .KEEP_BITS(KEEP_BITS)) u_link (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk       (sclk),
        .cs_n       (cs_n),
        .mosi       (mosi),
        .tx_word    (tx_word),
        .miso       (miso),
        .frame_done (frame_done),
        .rx_word    (rx_word)
    );

    assign frm_valid  = rx_word[KEEP_BITS-1] && (rx_word[KEEP_BITS-2 -: 2] == 2'b00);
    assign frm_addr   = rx_word[DATA_W +: ADDR_W];
    assign frm_data   = rx_word[DATA_W-1:0];
    assign wr_en      = frame_done && frm_valid;
    assign key_wr     = wr_en && (frm_addr == A_KEY);
    assign cfg_retrig = wr_en && (frm_addr == A_DAC_CFG) &&
                        ((frm_data[3:0]  != dac_cfg_q[3:0]) ||
                         (frm_data[15:8] != dac_cfg_q[15:8]));

    spi_regif_keyseq u_keys (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_wr   (key_wr),
        .key_val  (frm_data),
        .soft_rst (soft_rst),
        .cal_go   (cal_go),
        .wdt_go   (wdt_go),
        .bad_key  (bad_key)
    );

    spi_regif_caltimer #(.CYCLES(CAL_CYCLES)) u_cal (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (soft_rst),
        .start (cal_go | cfg_retrig),
        .busy  (cal_busy)
    );

    always_comb begin
        flags_d = flags_q;
        if (wr_en && frm_addr == A_DIAG_RES) flags_d = flags_q & ~frm_data[FLAG_W-1:0];
        if (frame_done && !frm_valid)        flags_d[0] = 1'b1;
        if (bad_key)                         flags_d[1] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dac_in_q   <= '0;
            dac_cfg_q  <= '0;
            diag_cfg_q <= '0;
            rb_sel_q   <= '0;
            flags_q    <= FLAGS_RESET;
        end else if (soft_rst) begin
            dac_in_q   <= '0;
            dac_cfg_q  <= '0;
            diag_cfg_q <= '0;
            rb_sel_q   <= '0;
            flags_q    <= FLAGS_RESET;
        end else begin
            flags_q <= flags_d;
            if (wr_en) begin
                case (frm_addr)
                    A_DAC_IN:   dac_in_q   <= frm_data;
                    A_DAC_CFG:  dac_cfg_q  <= frm_data;
                    A_DIAG_CFG: diag_cfg_q <= frm_data;
                    A_RB_SEL:   rb_sel_q   <= frm_data[ADDR_W-1:0];
                    default:    ;
                endcase
            end
        end
    end

    assign crc_en = (diag_cfg_q != CRC_OFF_CODE);

    always_comb begin
        case (rb_sel_q)
            A_DAC_IN:   rdata = dac_in_q;
            A_DAC_CFG:  rdata = dac_cfg_q;
            A_DIAG_CFG: rdata = diag_cfg_q;
            A_RB_SEL:   rdata = {{(DATA_W-ADDR_W){1'b0}}, rb_sel_q};
            A_DIAG_RES: rdata = {cal_busy, {(DATA_W-1-FLAG_W){1'b0}}, flags_q};
            A_STATUS:   rdata = {{(DATA_W-2){1'b0}}, cal_busy, crc_en};
            default:    rdata = '0;
        endcase
    end

    assign tx_word  = {{PAD_BITS{1'b0}}, rdata, 8'h00};
    assign dac_code = dac_in_q;
    assign dac_cfg  = dac_cfg_q;
    assign wdt_kick = wdt_go;

endmodule

// File: rtl/spi_regif_chk.sv
module spi_regif_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        frame_done,
    input logic        frm_valid,
    input logic        soft_rst,
    input logic        cal_go,
    input logic        cal_busy,
    input logic        wdt_kick,
    input logic        bad_key,
    input logic [15:0] dac_code,
    input logic [2:0]  flags_q,
    input logic [4:0]  rb_sel_q
);
    // R1
    frame_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    // R12
    invalid_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && !frm_valid) |=> (flags_q[0] && $stable(dac_code)));

    // R5
    reset_defaults_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (dac_code == 16'h0 && rb_sel_q == 5'h0 && flags_q == 3'b100));

    // R7
    cal_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cal_go |=> cal_busy);

    // R6
    key_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({soft_rst, cal_go, wdt_kick, bad_key}));

    // R9
    kick_on_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_kick |-> frame_done);
endmodule

bind spi_regif spi_regif_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_done (frame_done),
    .frm_valid  (frm_valid),
    .soft_rst   (soft_rst),
    .cal_go     (cal_go),
    .cal_busy   (cal_busy),
    .wdt_kick   (wdt_kick),
    .bad_key    (bad_key),
    .dac_code   (dac_code),
    .flags_q    (flags_q),
    .rb_sel_q   (rb_sel_q)
);

// File: tb/spi_regif_tb.sv
module spi_regif_tb_top;
    localparam int HALF = 6;
    localparam int CALN = 800;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic cs_n = 1'b1;
    logic mosi = 1'b0;
    logic        miso;
    logic [15:0] dac_code, dac_cfg;
    logic        crc_en, wdt_kick;

    always #10 clk = ~clk;

    spi_regif #(.CAL_CYCLES(CALN)) dut_i (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
        .miso(miso), .dac_code(dac_code), .dac_cfg(dac_cfg),
        .crc_en(crc_en), .wdt_kick(wdt_kick)
    );

    int checks = 0;
    int fails  = 0;
    int kicks  = 0;
    bit done   = 0;

    logic [15:0] m_dac, m_cfg, m_dcfg;
    logic [4:0]  m_sel;
    logic [2:0]  m_flg;

    always @(negedge clk) if (wdt_kick) kicks++;

    task automatic model_reset();
        m_dac = 0; m_cfg = 0; m_dcfg = 0; m_sel = 0; m_flg = 3'b100;
    endtask

    function automatic logic [15:0] exp_read(input logic [4:0] a);
        case (a)
            5'h01:   return m_dac;
            5'h06:   return m_cfg;
            5'h10:   return m_dcfg;
            5'h13:   return {11'b0, m_sel};
            5'h14:   return {13'b0, m_flg};
            5'h16:   return {15'b0, (m_dcfg != 16'h5C3A)};
            default: return 16'h0;
        endcase
    endfunction

    function automatic logic [15:0] busy_mask(input logic [4:0] a);
        if (a == 5'h14) return 16'h7FFF;
        if (a == 5'h16) return 16'hFFFD;
        return 16'hFFFF;
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic spi_frame(input logic [31:0] w, input int nbits, output logic [31:0] r);
        r = '0;
        @(negedge clk);
        cs_n = 1'b0;
        mosi = w[31];
        for (int i = 0; i < nbits; i++) begin
            mosi = w[31-i];
            repeat (HALF) @(negedge clk);
            r[31-i] = miso;
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (2*HALF) @(negedge clk);
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        logic [31:0] r;
        spi_frame({3'b100, a, d, 8'($urandom)}, 32, r);
        case (a)
            5'h01: m_dac = d;
            5'h06: m_cfg = d;
            5'h10: m_dcfg = d;
            5'h13: m_sel = d[4:0];
            5'h14: m_flg = m_flg & ~d[2:0];
            default: ;
        endcase
    endtask

    task automatic rd(input logic [4:0] a, output logic [15:0] d);
        logic [31:0] r;
        wr(5'h13, {11'b0, a});
        spi_frame(32'h8000_0000, 32, r);
        d = r[23:8];
        if (r[31:24] !== 8'h00 || r[7:0] !== 8'h00) begin
            checks++; fails++;
            $display("FAIL R2 actual=%h expected=00xxxx00", r);
        end
    endtask

    task automatic rd_chk(input string tag, input logic [4:0] a, input logic [15:0] mask);
        logic [15:0] d;
        rd(a, d);
        check(tag, d & mask, exp_read(a) & mask);
    endtask

    task automatic rd_val(input string tag, input logic [4:0] a, input logic [15:0] exp);
        logic [15:0] d;
        rd(a, d);
        check(tag, d, exp);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        int k0;
        void'($urandom(32'd4242));
        model_reset();
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R4 reset state
        check("R4 dac_code", dac_code, 16'h0);
        check("R4 crc_en", crc_en, 1'b1);
        rd_val("R4 dac_in", 5'h01, 16'h0);
        rd_val("R4 dac_cfg", 5'h06, 16'h0);
        rd_val("R4 diag_cfg", 5'h10, 16'h0);
        rd_val("R4 diag_res", 5'h14, 16'h0004);
        rd_val("R4 status", 5'h16, 16'h0001);

        // R1 write, then a short word is dropped
        wr(5'h01, 16'h1234);
        rd_val("R1 write", 5'h01, 16'h1234);
        check("R1 port", dac_code, 16'h1234);
        spi_frame({8'h81, 16'hFFFF, 8'h00}, 31, r);
        rd_val("R1 short word", 5'h01, 16'h1234);

        // R10 low byte has no effect
        spi_frame({8'h81, 16'h2222, 8'hFF}, 32, r);
        rd_val("R10 low byte ff", 5'h01, 16'h2222);
        spi_frame({8'h81, 16'h2222, 8'h00}, 32, r);
        rd_val("R10 low byte 00", 5'h01, 16'h2222);
        m_dac = 16'h2222;

        // R12 illegal command bits
        spi_frame({8'h01, 16'hBEEF, 8'h00}, 32, r);
        spi_frame({8'hA1, 16'hBEEF, 8'h00}, 32, r);
        m_flg[0] = 1'b1;
        rd_val("R12 dac kept", 5'h01, 16'h2222);
        rd_val("R12 flag", 5'h14, 16'h0005);

        // R11 write-one-to-clear
        wr(5'h14, 16'h0001);
        rd_val("R11 clear bit0", 5'h14, 16'h0004);
        wr(5'h14, 16'h0004);
        rd_val("R11 clear bit2", 5'h14, 16'h0000);

        // R3 unimplemented addresses
        wr(5'h1E, 16'hABCD);
        rd_val("R3 addr 1e", 5'h1E, 16'h0);
        rd_val("R3 key reads 0", 5'h08, 16'h0);
        rd_val("R3 addr 02", 5'h02, 16'h0);

        // R9 watchdog kick
        k0 = kicks;
        wr(5'h08, 16'h0D06);
        check("R9 one kick", kicks, k0 + 1);

        // R6 bad keys and cancelled reset
        wr(5'h08, 16'h1234);
        m_flg[1] = 1'b1;
        rd_val("R6 unknown key", 5'h14, 16'h0002);
        wr(5'h14, 16'h0002);
        wr(5'h08, 16'h15FA);
        wr(5'h08, 16'h0D06);
        wr(5'h08, 16'hAF51);
        m_flg[1] = 1'b1;
        rd_val("R6 cancelled reset", 5'h01, 16'h2222);
        rd_val("R6 lone second key", 5'h14, 16'h0002);

        // R5 software reset through an intervening ordinary write
        wr(5'h14, 16'h0007);
        wr(5'h10, 16'h1111);
        wr(5'h08, 16'h15FA);
        wr(5'h01, 16'h7777);
        wr(5'h08, 16'hAF51);
        model_reset();
        check("R5 port dac", dac_code, 16'h0);
        rd_val("R5 dac_in", 5'h01, 16'h0);
        rd_val("R5 diag_cfg", 5'h10, 16'h0);
        rd_val("R5 diag_res", 5'h14, 16'h0004);

        // R7 calibration refresh busy window
        wr(5'h08, 16'hFCBA);
        rd_val("R7 busy set", 5'h14, 16'h8004);
        repeat (CALN + 100) @(negedge clk);
        rd_val("R7 busy clear", 5'h14, 16'h0004);
        wr(5'h08, 16'hFCBA);
        rd_val("R7 status busy", 5'h16, 16'h0003);
        repeat (CALN + 100) @(negedge clk);

        // R8 retrigger by range/slew changes only
        wr(5'h06, 16'h0001);
        rd_val("R8 range change", 5'h14, 16'h8004);
        repeat (CALN + 100) @(negedge clk);
        wr(5'h06, 16'h00F1);
        rd_val("R8 middle bits only", 5'h14, 16'h0004);
        wr(5'h06, 16'h02F1);
        rd_val("R8 slew change", 5'h14, 16'h8004);
        check("R8 cfg port", dac_cfg, 16'h02F1);
        repeat (CALN + 100) @(negedge clk);

        // R10 integrity off code
        wr(5'h10, 16'h5C3A);
        check("R10 crc_en", crc_en, 1'b0);
        rd_val("R10 status", 5'h16, 16'h0000);

        // R2 random writes and two-frame reads
        for (int it = 0; it < 40; it++) begin
            logic [4:0] wa, ra;
            wa = 5'($urandom_range(0, 31));
            if (wa == 5'h08 || wa == 5'h13) wa = 5'h01;
            wr(wa, 16'($urandom));
            ra = 5'($urandom_range(0, 31));
            if (ra == 5'h08) ra = 5'h06;
            rd_chk("R2 random read", ra, busy_mask(ra));
            check("R2 port dac", dac_code, m_dac);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule